// File: doc/BRIEF.md
# SDRAM Burst Write Command Sequencer

This block takes one burst write request of four data words and turns it into the command stream that a synchronous DRAM expects on its pins. The stream opens the target row with a bank activate. Four column writes follow on consecutive cycles, each carrying its own data word and byte masks. The last of the four writes asks the device to precharge the bank by itself. The sequencer then counts out a write-recovery interval and a precharge interval, each set by a 2-bit field. Only after both intervals does it take another request.

A memory controller uses it as the write engine for one chip select. The controller presents the request with a ready/valid handshake. It watches the per-bank busy flag to learn when the bank that was written may be opened again. The recovery and precharge fields and the whole request are captured on the accepting clock edge. Changing the request inputs later has no effect on a burst that is already running.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset, and whenever reset is asserted in the middle of a burst, the pins show a deselect {cs_n,ras_n,cas_n,we_n}=1111, `req_ready` is 1, `bank_busy` is 0, `sd_dq_oe` is 0, `sd_addr`/`sd_ba`/`sd_dq` are 0 and `sd_dqm` is all ones.
- R2: In the cycle after a handshake (`req_valid` and `req_ready` high at a clock edge), the pins show activate 0011 with `sd_addr` equal to the row and `sd_ba` equal to the bank.
- R3: The next three cycles each show write 0100 with `sd_ba` equal to the bank. `sd_addr` holds the start column plus 0, 1 and 2 in bits COL_W-1:0, and the precharge bit `sd_addr[AP_BIT]` (bit 10) is 0.
- R4: The fourth write cycle shows write 0100 with the start column plus 3 and `sd_addr[AP_BIT]`=1, which requests auto-precharge.
- R5: In write beat b (0..3), `sd_dq` is `req_data[b*DATA_W +: DATA_W]` and `sd_dqm` is `req_mask[b*MASK_W +: MASK_W]`, with `sd_dq_oe`=1. In every other cycle `sd_dq_oe`=0, `sd_dq`=0 and `sd_dqm` is all ones.
- R6: After the auto-precharge write there are `rec_sel`+1 write-recovery cycles showing NOP 0111, with `sd_addr` and `sd_ba` 0.
- R7: After recovery there are `pre_sel`+1 precharge-wait cycles showing NOP 0111. The cycle after the last of them shows a deselect with `req_ready`=1.
- R8: `bank_busy` has only the bit of the request's bank set, from the activate cycle through the last precharge-wait cycle. It is 0 in every other cycle.
- R9: `req_ready` is 1 only when no burst is running. A `req_valid` or a change of request fields during a burst does not alter that burst's commands, addresses or data.
- R10: Column addresses wrap modulo 2^COL_W, so a start column of 0x3FE gives 0x3FE, 0x3FF, 0x000, 0x001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle; request taken at edge when valid |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Start column |
| req_data | input | 4*DATA_W | Four data words, beat 0 in the low bits |
| req_mask | input | 4*MASK_W | Four byte-mask groups, beat 0 in the low bits |
| rec_sel | input | 2 | Write-recovery cycles minus one |
| pre_sel | input | 2 | Precharge-wait cycles minus one |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Address pins |
| sd_ba | output | BANK_W | Bank pins |
| sd_dqm | output | MASK_W | Byte masks, 1 masks the byte |
| sd_dq | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data driver enable |
| bank_busy | output | 2**BANK_W | Per-bank busy flags |

## Verification
The bench uses the default parameters: 13 row bits, 10 column bits, four banks, 32-bit data and auto-precharge at address bit 10. With these values all sixteen pairings of the recovery and precharge fields fit in one short table, and each bank index comes up. A start column two below the top of the 10-bit range is short enough to reach the column wrap. The bench also holds request valid high with scrambled fields during each burst, which tests that the captured request cannot be disturbed, and it asserts reset in the middle of a burst.

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int DATA_W = 32,
  parameter int AP_BIT = 10,
  parameter int MASK_W = DATA_W / 8,
  parameter int NBANK  = 2 ** BANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [COL_W-1:0]      req_col,
  input  logic [4*DATA_W-1:0]   req_data,
  input  logic [4*MASK_W-1:0]   req_mask,
  input  logic [1:0]            rec_sel,
  input  logic [1:0]            pre_sel,
  output logic                  sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [ROW_W-1:0]      sd_addr,
  output logic [BANK_W-1:0]     sd_ba,
  output logic [MASK_W-1:0]     sd_dqm,
  output logic [DATA_W-1:0]     sd_dq,
  output logic                  sd_dq_oe,
  output logic [NBANK-1:0]      bank_busy
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_WR = 3'd2, S_REC = 3'd3, S_PRE = 3'd4;
  localparam logic [3:0] C_DESEL = 4'b1111, C_ACT = 4'b0011, C_WR = 4'b0100, C_NOP = 4'b0111;

  logic [2:0]          state;
  logic [1:0]          cnt;
  logic [BANK_W-1:0]   bank_q;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [4*DATA_W-1:0] data_q;
  logic [4*MASK_W-1:0] mask_q;
  logic [1:0]          rec_q, pre_q;
  logic [3:0]          cmd;
  logic [COL_W-1:0]    col_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      rec_q  <= '0;
      pre_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state  <= S_ACT;
          bank_q <= req_bank;
          row_q  <= req_row;
          col_q  <= req_col;
          data_q <= req_data;
          mask_q <= req_mask;
          rec_q  <= rec_sel;
          pre_q  <= pre_sel;
        end
        S_ACT: begin
          state <= S_WR;
          cnt   <= '0;
        end
        S_WR: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= S_REC;
        end
        S_REC: begin
          if (cnt == rec_q) begin
            state <= S_PRE;
            cnt   <= '0;
          end else cnt <= cnt + 2'd1;
        end
        S_PRE: begin
          if (cnt == pre_q) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign col_now   = col_q + COL_W'(cnt);

  always_comb begin
    case (state)
      S_IDLE:  cmd = C_DESEL;
      S_ACT:   cmd = C_ACT;
      S_WR:    cmd = C_WR;
      default: cmd = C_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_comb begin
    sd_addr = '0;
    if (state == S_ACT) sd_addr = row_q;
    else if (state == S_WR) begin
      sd_addr[COL_W-1:0] = col_now;
      sd_addr[AP_BIT]    = (cnt == 2'd3);
    end
  end

  assign sd_ba     = (state == S_ACT || state == S_WR) ? bank_q : '0;
  assign sd_dq_oe  = (state == S_WR);
  assign sd_dq     = sd_dq_oe ? data_q[cnt*DATA_W +: DATA_W] : '0;
  assign sd_dqm    = sd_dq_oe ? mask_q[cnt*MASK_W +: MASK_W] : '1;
  assign bank_busy = (state == S_IDLE) ? '0 : (NBANK'(1) << bank_q);
endmodule

module sdram_wr_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int AP_BIT = 10,
  parameter int NBANK  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe,
  input logic [NBANK-1:0] bank_busy
);
  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R2
  act_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> c == 4'b0011);
  // R3
  write_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0011 |=> c == 4'b0100 && !sd_addr[AP_BIT]);
  // R4
  rec_after_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0100 && sd_addr[AP_BIT] |=> c == 4'b0111 && bank_busy != '0);
  // R5
  oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> c == 4'b0100);
  // R8
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy));
  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> c == 4'b1111 && bank_busy == '0);
endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(.ROW_W(ROW_W), .AP_BIT(AP_BIT), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe), .bank_busy(bank_busy));

// File: tb/tb_sdram_wr_seq.sv
module tb_sdram_wr_seq;
  localparam int ROW_W = 13, COL_W = 10, BANK_W = 2, DATA_W = 32, AP_BIT = 10;
  localparam int MASK_W = DATA_W / 8, NBANK = 4;

  logic clk = 0, rst_n = 0, req_valid = 0, req_ready;
  logic [BANK_W-1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic [4*DATA_W-1:0] req_data = 0;
  logic [4*MASK_W-1:0] req_mask = 0;
  logic [1:0] rec_sel = 0, pre_sel = 0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [ROW_W-1:0] sd_addr;
  logic [BANK_W-1:0] sd_ba;
  logic [MASK_W-1:0] sd_dqm;
  logic [DATA_W-1:0] sd_dq;
  logic [NBANK-1:0] bank_busy;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  sdram_wr_seq dut (.*);

  // {rec, pre, bank, row, col}
  localparam logic [28:0] VEC [16] = '{
    {2'd0, 2'd0, 2'd0, 13'h0123, 10'h000}, {2'd0, 2'd1, 2'd1, 13'h1FFF, 10'h004},
    {2'd0, 2'd2, 2'd2, 13'h0AAA, 10'h3FE}, {2'd0, 2'd3, 2'd3, 13'h1555, 10'h010},
    {2'd1, 2'd0, 2'd3, 13'h0001, 10'h3FC}, {2'd1, 2'd1, 2'd2, 13'h0F0F, 10'h155},
    {2'd1, 2'd2, 2'd1, 13'h1000, 10'h2AA}, {2'd1, 2'd3, 2'd0, 13'h0777, 10'h3FF},
    {2'd2, 2'd0, 2'd1, 13'h0042, 10'h008}, {2'd2, 2'd1, 2'd3, 13'h1234, 10'h100},
    {2'd2, 2'd2, 2'd0, 13'h0ABC, 10'h3FD}, {2'd2, 2'd3, 2'd2, 13'h1DEF, 10'h020},
    {2'd3, 2'd0, 2'd2, 13'h0999, 10'h001}, {2'd3, 2'd1, 2'd0, 13'h0333, 10'h3FE},
    {2'd3, 2'd2, 2'd3, 13'h1888, 10'h0C0}, {2'd3, 2'd3, 2'd1, 13'h0666, 10'h200}
  };

  function automatic logic [DATA_W-1:0] dword(int v, int b);
    return 32'hA500_0000 ^ DATA_W'(v << 12) ^ DATA_W'(b * 32'h0101_0011);
  endfunction
  function automatic logic [MASK_W-1:0] dmask(int v, int b);
    return MASK_W'(v * 3 + b * 5);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_ready, bank_busy, sd_dq_oe},
        {4'b1111, 1'b1, 4'b0000, 1'b0});
    chk(req, {sd_addr, sd_ba, sd_dq, sd_dqm}, {13'h0, 2'h0, 32'h0, 4'hF});
  endtask

  task automatic run_vec(int v);
    logic [1:0] rec, pre, bank;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] ea;
    int total;
    {rec, pre, bank, row, col} = VEC[v];
    total = 5 + rec + 1 + pre + 1;
    @(negedge clk);
    req_valid = 1; req_bank = bank; req_row = row; req_col = col;
    rec_sel = rec; pre_sel = pre;
    for (int b = 0; b < 4; b++) begin
      req_data[b*DATA_W +: DATA_W] = dword(v, b);
      req_mask[b*MASK_W +: MASK_W] = dmask(v, b);
    end
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      chk("R8", {60'h0, bank_busy}, {60'h0, 4'b0001 << bank});
      chk("R9", {63'h0, req_ready}, 64'h0);
      if (i == 0) begin
        chk("R2", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba},
            {4'b0011, row, bank});
        chk("R5", {sd_dq_oe, sd_dq, sd_dqm}, {1'b0, 32'h0, 4'hF});
        // R9: scramble request fields while the burst runs
        req_bank = ~bank; req_row = ~row; req_col = ~col; req_data = ~req_data;
        req_mask = ~req_mask; rec_sel = ~rec; pre_sel = ~pre;
      end else if (i <= 4) begin
        ea = '0;
        ea[COL_W-1:0] = col + COL_W'(i - 1);
        ea[AP_BIT] = (i == 4);
        chk(i == 4 ? "R4" : (col > 10'h3FC ? "R10" : "R3"),
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba}, {4'b0100, ea, bank});
        chk("R5", {sd_dq_oe, sd_dq, sd_dqm}, {1'b1, dword(v, i - 1), dmask(v, i - 1)});
      end else begin
        chk(i <= 5 + rec ? "R6" : "R7",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba}, {4'b0111, 13'h0, 2'h0});
        chk("R5", {sd_dq_oe, sd_dq, sd_dqm}, {1'b0, 32'h0, 4'hF});
      end
      if (i == total - 1) req_valid = 0;
    end
    @(negedge clk);
    chk_idle("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_idle("R1");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");
    for (int v = 0; v < 16; v++) run_vec(v);
    // Reset in the middle of a burst
    @(negedge clk);
    req_valid = 1; req_bank = 2'd2; req_row = 13'h0055; req_col = 10'h0;
    rec_sel = 2'd3; pre_sel = 2'd3;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk("R3", {60'h0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {60'h0, 4'b0100});
    rst_n = 0;
    #1;
    chk_idle("R1");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");
    // Idle with no request stays deselected
    repeat (3) @(negedge clk);
    chk_idle("R9");
    run_vec(2);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule